// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Front End

This block is the byte-wide host-facing register front end of a two-channel serial communications controller. A host performs one access per clock: a write or read strobe plus a 2-bit offset. The offset picks a channel and either its control port or its data port. Control-port registers are reached indirectly. A first write loads a register pointer, and the following write or read goes to the register it names.

The block holds the status bits and interrupt-pending flags that this access path touches. A data-port write hands a byte to the transmitter. It marks the transmitter empty and all characters sent, and it raises the underrun and transmit-interrupt flags. When local loopback is on, the byte also appears as received data. Two event inputs per channel stand in for the external-status and baud-rate interrupt sources. The single interrupt output is the OR of every pending flag of both channels.

Top module: `dual_sio_regif`

## Requirements
- R1: Offset bit 0 selects the channel (1 = channel A, 0 = channel B). Offset bit 1 selects the port (1 = data, 0 = control). Offsets 0..3 are therefore B control, A control, B data and A data.
- R2: In the idle state, a control write whose bits 7:4 are zero loads bits 3:0 into the register pointer and enters the pointer-set state.
- R3: In the pointer-set state, the next control write lands in the pointed write register of the channel addressed by that write, whichever channel loaded the pointer, and the state returns to idle. Write register 5 bit 3 is transmit enable. Write register 14 bit 4 is local loopback.
- R4: In the idle state, a control write of 0x10 clears the addressed channel's external-status and baud pending flags. Any other idle control write with nonzero bits 7:4 changes nothing.
- R5: While a control read is presented, read data is the pointed read register of the addressed channel. Register 0 holds bit 2 transmit empty and bit 0 receive available. Register 1 bit 0 is all sent. Register 3 holds bit 0 external, bit 1 baud, bit 2 underrun and bit 3 transmit pending. Register 8 is the receive byte, and every other register reads 0. After the read, a pointer-set state returns to idle; otherwise the pointer resets to 0.
- R6: A data write with transmit enable set stores the byte on that channel's transmit byte output. It sets all sent, transmit empty, underrun pending and transmit pending. With transmit enable clear, a data write changes nothing.
- R7: An accepted data write with loopback set also loads the byte as receive data and sets receive available.
- R8: While a data read is presented, read data is the channel's receive byte; the read clears that channel's receive-available bit.
- R9: An external or baud event input sets that channel's flag. An event arriving in the same cycle as a 0x10 clear on the same channel wins.
- R10: The interrupt output is high exactly when any pending flag of either channel is set. It follows a flag change in the cycle after the access edge.
- R11: After reset all flags and registers are zero, the pointer is 0 and idle, the interrupt output is low, and read data is 0 when no read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 2 | Port offset (bit 0 channel, bit 1 data/control) |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, combinational during a read |
| ext_evt | input | 2 | External-status event per channel (bit 1 = A) |
| baud_evt | input | 2 | Baud-rate event per channel (bit 1 = A) |
| tx_byte_b | output | 8 | Last accepted transmit byte, channel B |
| tx_byte_a | output | 8 | Last accepted transmit byte, channel A |
| irq | output | 1 | Combined interrupt request |

## Verification
A pointer left in the wrong state sends the very next control access to the wrong register. That error shows as a wrong read byte, or as a write silently lost, on the following access. A wrong pending flag shows on `irq` one edge after the access that caused it, and in the register 3 bits the next time that register is read. The bench therefore compares the interrupt line and both transmit bytes after every edge. It compares read data on every read, so a divergence is caught within one access.

// File: rtl/dual_sio_regif.sv
module dual_sio_regif (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic [1:0] acc_off,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic [1:0] ext_evt,
  input  logic [1:0] baud_evt,
  output logic [7:0] tx_byte_b,
  output logic [7:0] tx_byte_a,
  output logic       irq
);
  localparam int NCH       = 2;
  localparam int BW        = 8;
  localparam int PW        = 4;
  localparam logic [PW-1:0] WR_TXCFG = 4'd5;
  localparam logic [PW-1:0] WR_LOOP  = 4'd14;
  localparam logic [BW-1:0] CMD_CLR  = 8'h10;

  logic [PW-1:0] ptr;
  logic          ptr_set;
  logic [NCH-1:0][BW-1:0] wr5, wr14, rx_q, tx_q;
  logic [NCH-1:0] rx_av, tx_mt, all_sent, ext_p, baud_p, und_p, txi_p;

  wire ch      = acc_off[0];
  wire is_data = acc_off[1];
  wire ctl_wr  = acc_en &  acc_wr & ~is_data;
  wire ctl_rd  = acc_en & ~acc_wr & ~is_data;
  wire dat_wr  = acc_en &  acc_wr &  is_data;
  wire dat_rd  = acc_en & ~acc_wr &  is_data;
  wire cmd_ptr = ctl_wr & ~ptr_set & (acc_wdata[BW-1:PW] == '0);
  wire cmd_clr = ctl_wr & ~ptr_set & (acc_wdata == CMD_CLR);
  wire reg_wr  = ctl_wr & ptr_set;
  wire tx_ok   = dat_wr & wr5[ch][3];
  wire loop_ok = tx_ok & wr14[ch][4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      ptr_set <= 1'b0;
    end else if (cmd_ptr) begin
      ptr     <= acc_wdata[PW-1:0];
      ptr_set <= 1'b1;
    end else if (reg_wr) begin
      ptr_set <= 1'b0;
    end else if (ctl_rd) begin
      if (ptr_set) ptr_set <= 1'b0;
      else         ptr     <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr5 <= '0; wr14 <= '0; rx_q <= '0; tx_q <= '0;
      rx_av <= '0; tx_mt <= '0; all_sent <= '0;
      ext_p <= '0; baud_p <= '0; und_p <= '0; txi_p <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_wr && ch == 1'(i) && ptr == WR_TXCFG) wr5[i]  <= acc_wdata;
        if (reg_wr && ch == 1'(i) && ptr == WR_LOOP)  wr14[i] <= acc_wdata;
        if (tx_ok && ch == 1'(i)) begin
          tx_q[i]     <= acc_wdata;
          all_sent[i] <= 1'b1;
          tx_mt[i]    <= 1'b1;
          und_p[i]    <= 1'b1;
          txi_p[i]    <= 1'b1;
        end
        if (loop_ok && ch == 1'(i)) begin
          rx_q[i]  <= acc_wdata;
          rx_av[i] <= 1'b1;
        end else if (dat_rd && ch == 1'(i)) begin
          rx_av[i] <= 1'b0;
        end
        ext_p[i]  <= ext_evt[i]  | (ext_p[i]  & ~(cmd_clr && ch == 1'(i)));
        baud_p[i] <= baud_evt[i] | (baud_p[i] & ~(cmd_clr && ch == 1'(i)));
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (dat_rd) acc_rdata = rx_q[ch];
    else if (ctl_rd) begin
      case (ptr)
        4'd0:    acc_rdata = {5'b0, tx_mt[ch], 1'b0, rx_av[ch]};
        4'd1:    acc_rdata = {7'b0, all_sent[ch]};
        4'd3:    acc_rdata = {4'b0, txi_p[ch], und_p[ch], baud_p[ch], ext_p[ch]};
        4'd8:    acc_rdata = rx_q[ch];
        default: acc_rdata = '0;
      endcase
    end
  end

  assign tx_byte_b = tx_q[0];
  assign tx_byte_a = tx_q[1];
  assign irq = |{ext_p, baud_p, und_p, txi_p};

  p_ptr_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr |=> ptr_set && ptr == $past(acc_wdata[PW-1:0]));
  p_ptr_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ptr_set) |=> !ptr_set);
  p_rd_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !ptr_set) |=> ptr == '0 && !ptr_set);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr && ext_evt == '0 && baud_evt == '0) |=> !ext_p[$past(ch)] && !baud_p[$past(ch)]);
  p_tx_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !wr5[ch][3]) |=> $stable(tx_q) && $stable(und_p) && $stable(txi_p));
  p_rx_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |=> !rx_av[$past(ch)]);
  p_irq_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> irq);
endmodule

// File: tb/dual_sio_regif_bench.sv
`timescale 1ns/1ps
module dual_sio_regif_bench;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, acc_wr = 0;
  logic [1:0] acc_off = 0, ext_evt = 0, baud_evt = 0;
  logic [7:0] acc_wdata = 0, acc_rdata, tx_byte_a, tx_byte_b;
  logic irq;

  dual_sio_regif u_dual_sio_regif (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_off(acc_off), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .ext_evt(ext_evt),
    .baud_evt(baud_evt), .tx_byte_b(tx_byte_b), .tx_byte_a(tx_byte_a), .irq(irq));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_ptr = 0, m_pset = 0;
  int m_wr5[2], m_wr14[2], m_rx[2], m_tx[2], m_rxav[2], m_txe[2], m_all[2];
  int m_ext[2], m_baud[2], m_und[2], m_txp[2];

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic int m_read(int c);
    case (m_ptr)
      0: return m_txe[c] * 4 + m_rxav[c];
      1: return m_all[c];
      3: return m_ext[c] + 2 * m_baud[c] + 4 * m_und[c] + 8 * m_txp[c];
      8: return m_rx[c];
      default: return 0;
    endcase
  endfunction

  function automatic int m_irq();
    int any = 0;
    for (int i = 0; i < 2; i++) any |= m_ext[i] | m_baud[i] | m_und[i] | m_txp[i];
    return any;
  endfunction

  task automatic acc(bit en, bit wr, int off, int d, int ee, int be, string tag);
    int c;
    @(negedge clk);
    acc_en = en; acc_wr = wr; acc_off = 2'(off); acc_wdata = 8'(d);
    ext_evt = 2'(ee); baud_evt = 2'(be);
    #8;
    c = off & 1;
    if (en && !wr) chk(tag, "rdata", 32'(acc_rdata), 32'((off >= 2) ? m_rx[c] : m_read(c)));
    if (!en) chk(tag, "rdata idle", 32'(acc_rdata), 0);
    if (en && wr && off < 2) begin
      if (m_pset == 0 && (d >> 4) == 0) begin m_ptr = d & 15; m_pset = 1; end
      else if (m_pset == 0 && d == 16) begin m_ext[c] = 0; m_baud[c] = 0; end
      else if (m_pset == 1) begin
        if (m_ptr == 5) m_wr5[c] = d;
        if (m_ptr == 14) m_wr14[c] = d;
        m_pset = 0;
      end
    end
    if (en && !wr && off < 2) begin
      if (m_pset == 1) m_pset = 0; else m_ptr = 0;
    end
    if (en && wr && off >= 2 && (m_wr5[c] & 8) != 0) begin
      m_tx[c] = d; m_all[c] = 1; m_txe[c] = 1; m_und[c] = 1; m_txp[c] = 1;
      if ((m_wr14[c] & 16) != 0) begin m_rx[c] = d; m_rxav[c] = 1; end
    end
    if (en && !wr && off >= 2) m_rxav[c] = 0;
    for (int i = 0; i < 2; i++) begin
      if (((ee >> i) & 1) != 0) m_ext[i] = 1;
      if (((be >> i) & 1) != 0) m_baud[i] = 1;
    end
    @(posedge clk); #1;
    chk(tag, "irq", 32'(irq), 32'(m_irq()));
    chk(tag, "tx_byte_a", 32'(tx_byte_a), 32'(m_tx[1]));
    chk(tag, "tx_byte_b", 32'(tx_byte_b), 32'(m_tx[0]));
    acc_en = 0; ext_evt = 0; baud_evt = 0;
  endtask

  task automatic cw(int off, int d, string tag); acc(1, 1, off, d, 0, 0, tag); endtask
  task automatic cr(int off, string tag);        acc(1, 0, off, 0, 0, 0, tag); endtask
  task automatic rreg(int off, int r, string tag); cw(off, r, tag); cr(off, tag); endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_wr5[i] = 0; m_wr14[i] = 0; m_rx[i] = 0; m_tx[i] = 0; m_rxav[i] = 0; m_txe[i] = 0;
      m_all[i] = 0; m_ext[i] = 0; m_baud[i] = 0; m_und[i] = 0; m_txp[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "irq in reset", 32'(irq), 0);
    chk("R11", "tx_byte_a in reset", 32'(tx_byte_a), 0);
    chk("R11", "rdata in reset", 32'(acc_rdata), 0);
    @(negedge clk); rst_n = 1;
    acc(0, 0, 0, 0, 0, 0, "R11");
    cr(1, "R11");
    rreg(1, 1, "R5");
    // R6 data write with transmit disabled is ignored
    acc(1, 1, 3, 8'hA5, 0, 0, "R6");
    rreg(1, 3, "R6");
    rreg(1, 0, "R6");
    // R2 R3 enable transmit on channel A
    cw(1, 5, "R2");
    cw(1, 8, "R3");
    acc(1, 1, 3, 8'h5A, 0, 0, "R6");
    rreg(1, 0, "R6");
    rreg(1, 1, "R6");
    rreg(1, 3, "R6");
    // R3 pointer loaded on B, register written on A: loopback on A
    cw(0, 14, "R3");
    cw(1, 8'h10, "R3");
    acc(1, 1, 3, 8'h3C, 0, 0, "R7");
    rreg(1, 0, "R7");
    rreg(1, 8, "R7");
    acc(1, 0, 3, 0, 0, 0, "R8");
    rreg(1, 0, "R8");
    // R1 channel B unaffected so far
    acc(1, 1, 2, 8'h11, 0, 0, "R1");
    rreg(0, 3, "R1");
    rreg(0, 0, "R1");
    acc(1, 0, 2, 0, 0, 0, "R1");
    // R9 events
    acc(0, 0, 0, 0, 2, 1, "R9");
    rreg(1, 3, "R9");
    rreg(0, 3, "R9");
    // R4 clear on B, other command on A ignored
    cw(0, 8'h10, "R4");
    rreg(0, 3, "R4");
    cw(1, 8'h20, "R4");
    rreg(1, 3, "R4");
    // R9 event wins over clear
    acc(1, 1, 1, 8'h10, 2, 2, "R9");
    rreg(1, 3, "R9");
    // R5 idle read resets pointer
    cw(0, 8, "R5");
    cr(0, "R5");
    cr(1, "R5");
    cr(1, "R5");
    // R6 R10 channel B transmit, no loopback
    cw(0, 5, "R10");
    cw(0, 8'h08, "R10");
    acc(1, 1, 2, 8'h77, 0, 0, "R10");
    rreg(0, 0, "R7");
    rreg(0, 3, "R10");
    acc(1, 0, 2, 0, 0, 0, "R8");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule